// File: doc/BRIEF.md
# Oversampled Three-Wire Serial Slave Transmitter

This block sends bytes to an external master over three wires. The master drives a serial clock and an active-low select line. The block drives back a single data line. Every register in the block runs on the local system clock, nominally 50 MHz. The master's serial clock is never used as a register clock. It is sampled as an ordinary input through a multi-stage synchronizer, optionally cleaned by a run-length glitch filter, and turned into a one-cycle edge strobe by comparing the current sample with the one before it. A ringing clock line can therefore advance the shifter at most once per accepted level change.

While select is high, the block keeps its shift register loaded from a parallel byte input, so the data line always shows the most significant bit of the next byte. Once select is low, each accepted shift edge moves the byte one place toward the data line, most significant bit first. The shift edge is rising by default and falling by parameter. On the last edge of a byte the block raises a one-cycle completion pulse and loads the next byte from the parallel input. The scheme is meant for serial clocks that are well below the system clock rate.

Top module: `spi3_tx_slave`

## Requirements
- R1: While reset is high, the data output and the completion pulse are 0. Within 4 cycles after reset falls, with select high, the data output equals bit 7 of the parallel byte.
- R2: While select is high, the data output follows bit 7 of the parallel byte, and serial clock edges neither shift data nor raise the completion pulse.
- R3: While select is low, each accepted shift edge presents the next lower bit of the current byte on the data output, starting from bit 7.
- R4: The completion pulse goes high for exactly one cycle after the 8th accepted shift edge of each byte, and at no other time.
- R5: On the 8th shift edge, the shift register is loaded from the parallel input, so bit 7 of the newly loaded byte appears on the data output and the following byte streams without a gap.
- R6: With a filter length N above 1, a serial clock level is accepted only after it has been sampled for N consecutive system clocks, so a pulse of 2 cycles is ignored when N=3. With N=1, a 2-cycle pulse counts as an edge.
- R7: With the falling-edge option, data advances on the falling transition of the serial clock and not on the rising one.
- R8: Raising select in the middle of a byte clears the bit count, so the next frame starts again at bit 7 and completes after a full 8 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers use it |
| rst | input | 1 | Synchronous reset, active high |
| sclkIn | input | 1 | Serial clock from the master, asynchronous |
| csnIn | input | 1 | Select from the master, active low, asynchronous |
| txByte | input | DATA_W | Parallel byte to be sent next |
| sdo | output | 1 | Serial data to the master |
| byteDone | output | 1 | One-cycle pulse when a byte has been fully shifted out |

## Verification
Three instances share one stimulus: a default rising-edge, unfiltered instance, one with a filter length of 3, and one that shifts on the falling edge. Frames of random length, random bytes and random half periods are checked bit by bit, both after the rising edge and after the falling edge. These checks separate the rising-edge and falling-edge variants, and they catch bit order and reload errors at byte boundaries. Directed cases cover serial clock activity while deselected, a frame aborted after three bits, and a 2-cycle clock glitch. The glitch test must move the unfiltered shifter and leave the filtered one unchanged. Completion pulses are counted per byte, which exposes stretched, missing or early pulses.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  // Strobes from the control to the shift datapath
  typedef struct packed {
    logic load;   // copy the parallel byte into the shifter
    logic shift;  // move the shifter one place toward the data line
  } dpStrobe_t;
endpackage

// File: rtl/spi3_tx_datapath.sv
module spi3_tx_datapath #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  spi3_pkg::dpStrobe_t  stb,
  input  logic [DATA_W-1:0]    txByte,
  output logic                 sdo
);
  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk) begin
    if (rst)            shReg <= '0;
    else if (stb.load)  shReg <= txByte;
    else if (stb.shift) shReg <= {shReg[DATA_W-2:0], 1'b0};
  end

  assign sdo = shReg[DATA_W-1];
endmodule

// File: rtl/spi3_tx_control.sv
module spi3_tx_control #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 1,
  parameter bit RISE_EDGE   = 1'b1,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclkIn,
  input  logic                csnIn,
  output spi3_pkg::dpStrobe_t stb,
  output logic                csSel,
  output logic                edgeHit,
  output logic [CNT_W-1:0]    bitCnt,
  output logic                byteDone
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  // Multi-stage synchronizers; select idles high (deselected)
  logic [SYNC_STAGES-1:0] sclkPipe, csnPipe;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclkPipe <= '0;
      csnPipe  <= '1;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
      csnPipe  <= {csnPipe[SYNC_STAGES-2:0], csnIn};
    end
  end

  logic sclkSync;
  assign sclkSync = sclkPipe[SYNC_STAGES-1];
  assign csSel    = ~csnPipe[SYNC_STAGES-1];

  // Optional run-length glitch filter
  logic sclkClean;
  generate
    if (FILTER_LEN <= 1) begin : g_noFilter
      assign sclkClean = sclkSync;
    end else begin : g_filter
      localparam int FLT_W = $clog2(FILTER_LEN);
      logic             fltLvl;
      logic [FLT_W-1:0] runLen;
      always_ff @(posedge clk) begin
        if (rst) begin
          fltLvl <= 1'b0;
          runLen <= '0;
        end else if (sclkSync == fltLvl) begin
          runLen <= '0;
        end else if (runLen == FLT_W'(FILTER_LEN - 1)) begin
          fltLvl <= sclkSync;
          runLen <= '0;
        end else begin
          runLen <= runLen + FLT_W'(1);
        end
      end
      assign sclkClean = fltLvl;
    end
  endgenerate

  // Two-sample history edge detection
  logic sclkPrev;
  always_ff @(posedge clk) begin
    if (rst) sclkPrev <= 1'b0;
    else     sclkPrev <= sclkClean;
  end

  generate
    if (RISE_EDGE) begin : g_rise
      assign edgeHit = sclkClean & ~sclkPrev;
    end else begin : g_fall
      assign edgeHit = ~sclkClean & sclkPrev;
    end
  endgenerate

  // Bit counting and strobe generation
  logic lastEdge;
  assign lastEdge = csSel && edgeHit && (bitCnt == LAST);

  always_comb begin
    stb = '0;
    if (!csSel)       stb.load  = 1'b1;
    else if (lastEdge) stb.load  = 1'b1;
    else if (edgeHit)  stb.shift = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt   <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= lastEdge;
      if (!csSel || lastEdge) bitCnt <= '0;
      else if (edgeHit)       bitCnt <= bitCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi3_tx_slave.sv
module spi3_tx_slave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 1,
  parameter bit RISE_EDGE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclkIn,
  input  logic              csnIn,
  input  logic [DATA_W-1:0] txByte,
  output logic              sdo,
  output logic              byteDone
);
  localparam int CNT_W = $clog2(DATA_W);

  spi3_pkg::dpStrobe_t stb;
  logic                csSel;
  logic                edgeHit;
  logic [CNT_W-1:0]    bitCnt;

  spi3_tx_control #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
    .FILTER_LEN(FILTER_LEN), .RISE_EDGE(RISE_EDGE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sclkIn(sclkIn), .csnIn(csnIn),
    .stb(stb), .csSel(csSel), .edgeHit(edgeHit),
    .bitCnt(bitCnt), .byteDone(byteDone)
  );

  spi3_tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .txByte(txByte), .sdo(sdo)
  );
endmodule

// File: rtl/spi3_tx_checker.sv
module spi3_tx_checker #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic                clk,
  input logic                rst,
  input logic                byteDone,
  input logic                csSel,
  input logic                edgeHit,
  input logic [CNT_W-1:0]    bitCnt,
  input spi3_pkg::dpStrobe_t stb
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  // R4: the completion pulse lasts one cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    byteDone |=> !byteDone);

  // R4: the pulse follows a selected edge
  a_r4_done_cause: assert property (@(posedge clk) disable iff (rst)
    byteDone |-> ($past(csSel) && $past(edgeHit)));

  // R2: deselect keeps the count cleared
  a_r2_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !csSel |=> (bitCnt == '0));

  // R3: each selected non-final edge advances the count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    (csSel && edgeHit && bitCnt != LAST) |=> (bitCnt == $past(bitCnt) + CNT_W'(1)));

  // R3: no edge, no count change while selected
  a_r3_count_hold: assert property (@(posedge clk) disable iff (rst)
    (csSel && !edgeHit) |=> $stable(bitCnt));

  // R5: the final edge wraps the count and signals completion
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (csSel && edgeHit && bitCnt == LAST) |=> (bitCnt == '0 && byteDone));

  // R3: load and shift are never requested together
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.load, stb.shift}));
endmodule

bind spi3_tx_slave spi3_tx_checker #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rst(rst), .byteDone(byteDone), .csSel(csSel),
  .edgeHit(edgeHit), .bitCnt(bitCnt), .stb(stb)
);

// File: tb/tb_spi3_tx_slave.sv
module tb_spi3_tx_slave;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       csn = 1'b1;
  logic [7:0] txByte = 8'hA5;
  logic       sdoR, sdoF, sdoL;
  logic       doneR, doneF, doneL;

  int checks = 0;
  int fails  = 0;
  int cntR = 0, cntF = 0, cntL = 0;
  bit finished = 0;
  logic [7:0] fb [0:4];

  always #10 clk = ~clk;  // 50 MHz

  spi3_tx_slave dut (
    .clk(clk), .rst(rst), .sclkIn(sclk), .csnIn(csn), .txByte(txByte),
    .sdo(sdoR), .byteDone(doneR));

  spi3_tx_slave #(.FILTER_LEN(3)) dutFilt (
    .clk(clk), .rst(rst), .sclkIn(sclk), .csnIn(csn), .txByte(txByte),
    .sdo(sdoF), .byteDone(doneF));

  spi3_tx_slave #(.RISE_EDGE(1'b0)) dutFall (
    .clk(clk), .rst(rst), .sclkIn(sclk), .csnIn(csn), .txByte(txByte),
    .sdo(sdoL), .byteDone(doneL));

  always @(posedge clk) begin
    if (!rst) begin
      if (doneR) cntR++;
      if (doneF) cntF++;
      if (doneL) cntL++;
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic bitOf(input logic [7:0] b, input int idx);
    return b[idx];
  endfunction

  task automatic runFrame(input int nb, input int half);
    int bR, bF, bL;
    logic eb, nxt;
    txByte = fb[0];
    waitCyc(half);
    csn = 1'b0;
    waitCyc(half);
    txByte = fb[1];
    for (int k = 0; k < nb; k++) begin
      bR = cntR; bF = cntF; bL = cntL;
      for (int i = 0; i < 8; i++) begin
        eb  = bitOf(fb[k], 7 - i);
        nxt = (i == 7) ? bitOf(fb[k+1], 7) : bitOf(fb[k], 6 - i);
        check(sdoR == eb, "R3 bit before edge", sdoR, eb);
        check(sdoF == eb, "R6 filtered bit before edge", sdoF, eb);
        check(sdoL == eb, "R7 falling bit before edge", sdoL, eb);
        sclk = 1'b1;
        waitCyc(half);
        check(sdoR == nxt, (i == 7) ? "R5 reload after rise" : "R3 shift on rise", sdoR, nxt);
        check(sdoF == nxt, "R6 filtered shift on rise", sdoF, nxt);
        check(sdoL == eb, "R7 no shift on rise", sdoL, eb);
        sclk = 1'b0;
        waitCyc(half);
        check(sdoL == nxt, "R7 shift on fall", sdoL, nxt);
      end
      check(cntR - bR == 1, "R4 one done pulse", cntR - bR, 1);
      check(cntF - bF == 1, "R4 one done pulse filtered", cntF - bF, 1);
      check(cntL - bL == 1, "R4 one done pulse falling", cntL - bL, 1);
      if (k + 2 <= nb) txByte = fb[k+2];
    end
    csn = 1'b1;
    waitCyc(half);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int c0;
    void'($urandom(32'd1789));
    waitCyc(3);
    // R1: reset state
    check(sdoR == 1'b0 && sdoF == 1'b0 && sdoL == 1'b0, "R1 sdo in reset", sdoR, 0);
    check(!doneR && !doneF && !doneL, "R1 done in reset", doneR, 0);
    rst = 1'b0;
    waitCyc(4);
    check(sdoR == 1'b1 && sdoF == 1'b1 && sdoL == 1'b1, "R1 first bit after reset", sdoR, 1);

    // R2: deselected tracking and ignored edges
    txByte = 8'h3C;
    c0 = cntR + cntF + cntL;
    for (int p = 0; p < 3; p++) begin
      sclk = 1'b1; waitCyc(8);
      sclk = 1'b0; waitCyc(8);
    end
    check(sdoR == 1'b0 && sdoF == 1'b0 && sdoL == 1'b0, "R2 idle follows byte", sdoR, 0);
    check(cntR + cntF + cntL == c0, "R2 no done while idle", cntR + cntF + cntL - c0, 0);
    txByte = 8'hC3;
    waitCyc(6);
    check(sdoR == 1'b1 && sdoL == 1'b1, "R2 idle reload", sdoR, 1);

    // Directed frame with boundary patterns
    fb[0] = 8'h80; fb[1] = 8'h01; fb[2] = 8'hFF;
    runFrame(2, 10);

    // Random frames
    for (int f = 0; f < 20; f++) begin
      int nb;
      nb = $urandom_range(3, 1);
      for (int j = 0; j < 5; j++) fb[j] = 8'($urandom);
      runFrame(nb, $urandom_range(16, 10));
    end

    // R8: abort mid-byte
    txByte = 8'hB4;
    waitCyc(10);
    csn = 1'b0;
    waitCyc(10);
    for (int p = 0; p < 3; p++) begin
      sclk = 1'b1; waitCyc(10);
      sclk = 1'b0; waitCyc(10);
    end
    csn = 1'b1;
    txByte = 8'h6D;
    waitCyc(10);
    check(sdoR == 1'b0 && sdoF == 1'b0 && sdoL == 1'b0, "R8 reload after abort", sdoR, 0);
    fb[0] = 8'h6D; fb[1] = 8'h92;
    runFrame(1, 12);

    // R6: 2-cycle glitch, unfiltered moves, filtered holds
    txByte = 8'h80;
    waitCyc(12);
    csn = 1'b0;
    waitCyc(12);
    sclk = 1'b1; waitCyc(2);
    sclk = 1'b0; waitCyc(12);
    check(sdoR == 1'b0, "R6 unfiltered takes glitch", sdoR, 0);
    check(sdoF == 1'b1, "R6 filtered ignores glitch", sdoF, 1);
    csn = 1'b1;
    waitCyc(12);

    finish_run();
  end
endmodule